// File: doc/BRIEF.md
# Single-Cell Charge Cycle Sequencer

This block walks a single lithium cell through one charge cycle from already digitized measurements. Each clock it takes the battery voltage and charge current in millivolts and milliamps, the converter-running flag, a group of enable conditions, three regulation-active flags (input current, input voltage, die temperature) and a handful of configuration fields. From these it picks the current mode the analog loop should apply, drives the battery-switch enable, and reports a 2-bit phase code. A done flag and a one-cycle completion strobe mark the end of a cycle.

A cycle ends once low charge current has been seen for a run of consecutive samples, the battery sits above the recharge level and no regulation loop is limiting the current. A finished battery that sags below a selectable offset under the regulation voltage starts again without outside help. Software can also restart it by toggling either enable. The timer, interrupt, ADC and converter logic sit in neighbouring blocks.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: A cycle runs only while the converter runs, the software enable is 1, the active-low enable pin is 0, no safety-timer fault is present and the switch-disable bit is 0. If any of these fails, the phase code returns to 00 at the next clock edge.
- R2: While charging, mode_o is 01 (short-battery) for a battery below SHORT_MV (2000 mV), 10 (precharge) from there up to below the low-battery threshold, and 11 (fast charge) at or above it. Outside charging, mode_o is 00.
- R3: The low-battery threshold is 2800 mV when vlow_sel_i is 0 and 3000 mV when it is 1.
- R4: stat_o reads 00 when not charging, 01 while charging below the low-battery threshold, 10 while charging at or above it, and 11 when done.
- R5: Termination needs charge current below iterm_ma_i, battery strictly above the recharge threshold and no regulation flag set, for TERM_SAMPLES (8) consecutive clock edges. A single miss restarts the count.
- R6: No termination occurs while term_en_i is 0.
- R7: No termination occurs while any of reg_iin_i, reg_vin_i or reg_therm_i is 1.
- R8: On termination stat_o becomes 11, done_o becomes 1, bsw_en_o becomes 0, and done_evt_o is 1 for exactly the first done cycle.
- R9: The recharge threshold is vreg_mv_i minus 100 mV when rech_sel_i is 0, and minus 200 mV when it is 1. A done battery strictly below it returns to charging on the next edge.
- R10: From done, taking the enable pin high or the software enable to 0 gives phase 00. Restoring it starts a new cycle.
- R11: After the asynchronous reset rst_ni, stat_o is 00, mode_o is 00, done_o and done_evt_o are 0, and bsw_en_o equals the inverse of bsw_dis_i.
- R12: A zero fast-charge code ichg_code_i blocks a cycle from starting and stops one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbat_mv_i | input | MV_W | Battery voltage, mV |
| ibat_ma_i | input | MV_W | Charge current, mA |
| vreg_mv_i | input | MV_W | Regulation voltage, mV |
| iterm_ma_i | input | MV_W | Termination current, mA |
| ichg_code_i | input | ICHG_W | Fast-charge current code, zero disables |
| conv_on_i | input | 1 | Converter running |
| sw_en_i | input | 1 | Software charge enable |
| en_n_i | input | 1 | Charge enable pin, active low |
| tmr_fault_i | input | 1 | Safety-timer fault |
| bsw_dis_i | input | 1 | Battery-switch disable |
| reg_iin_i | input | 1 | Input current regulation active |
| reg_vin_i | input | 1 | Input voltage regulation active |
| reg_therm_i | input | 1 | Thermal regulation active |
| vlow_sel_i | input | 1 | Low-battery threshold select |
| rech_sel_i | input | 1 | Recharge offset select |
| term_en_i | input | 1 | Termination enable |
| mode_o | output | 2 | Current mode: 00 off, 01 short, 10 pre, 11 fast |
| stat_o | output | 2 | Phase code |
| done_o | output | 1 | Cycle complete |
| bsw_en_o | output | 1 | Battery switch enable |
| done_evt_o | output | 1 | One-cycle completion strobe |

## Verification
Termination and loss of a start condition can both resolve on the same edge. The same holds for a regulation flag that rises on the eighth qualifying sample. The bench builds the eight-sample run and breaks it on its last edge, first with a current excursion and then by other means. It expects the phase to stay at 10 with no strobe, and it expects the count to restart so that termination lands exactly eight edges after the break. The scoreboard compares the whole output set at every checkpoint, so a strobe or switch change that leaks into a neighbouring cycle is caught.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CHG  = 2'b01,
    ST_DONE = 2'b10
  } chg_state_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_PRE   = 2'b10,
    MODE_FAST  = 2'b11
  } cur_mode_e;

  localparam logic [1:0] STAT_OFF  = 2'b00;
  localparam logic [1:0] STAT_PRE  = 2'b01;
  localparam logic [1:0] STAT_FAST = 2'b10;
  localparam logic [1:0] STAT_DONE = 2'b11;
endpackage

// File: rtl/chg_start_gate.sv
module chg_start_gate #(
  parameter int ICHG_W = 6
) (
  input  logic              conv_on_i,
  input  logic              sw_en_i,
  input  logic              en_n_i,
  input  logic              tmr_fault_i,
  input  logic              bsw_dis_i,
  input  logic [ICHG_W-1:0] ichg_code_i,
  output logic              start_ok_o
);
  assign start_ok_o = conv_on_i & sw_en_i & ~en_n_i & ~tmr_fault_i
                    & ~bsw_dis_i & (|ichg_code_i);
endmodule

// File: rtl/chg_mode_sel.sv
module chg_mode_sel
  import chg_pkg::*;
#(
  parameter int MV_W     = 16,
  parameter int SHORT_MV = 2000,
  parameter int VLOW0_MV = 2800,
  parameter int VLOW1_MV = 3000
) (
  input  logic            charging_i,
  input  logic [MV_W-1:0] vbat_mv_i,
  input  logic            vlow_sel_i,
  output cur_mode_e       mode_o,
  output logic            below_low_o
);
  logic [MV_W-1:0] vlow_mv;
  logic            below_short;

  assign vlow_mv     = vlow_sel_i ? MV_W'(VLOW1_MV) : MV_W'(VLOW0_MV);
  assign below_short = vbat_mv_i < MV_W'(SHORT_MV);
  assign below_low_o = vbat_mv_i < vlow_mv;

  always_comb begin
    if (!charging_i)      mode_o = MODE_OFF;
    else if (below_short) mode_o = MODE_SHORT;
    else if (below_low_o) mode_o = MODE_PRE;
    else                  mode_o = MODE_FAST;
  end
endmodule

// File: rtl/chg_term_qual.sv
module chg_term_qual #(
  parameter int MV_W         = 16,
  parameter int TERM_SAMPLES = 8,
  parameter int RECH0_MV     = 100,
  parameter int RECH1_MV     = 200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic [MV_W-1:0] vbat_mv_i,
  input  logic [MV_W-1:0] ibat_ma_i,
  input  logic [MV_W-1:0] vreg_mv_i,
  input  logic [MV_W-1:0] iterm_ma_i,
  input  logic            rech_sel_i,
  input  logic            term_en_i,
  input  logic            reg_any_i,
  output logic            rech_low_o,
  output logic            term_ok_o
);
  localparam int              CW      = (TERM_SAMPLES > 1) ? $clog2(TERM_SAMPLES) : 1;
  localparam logic [CW-1:0]   CNT_MAX = CW'(TERM_SAMPLES - 1);

  logic [MV_W-1:0] ofs_mv, rech_mv;
  logic            cond;
  logic [CW-1:0]   cnt_q;

  assign ofs_mv     = rech_sel_i ? MV_W'(RECH1_MV) : MV_W'(RECH0_MV);
  assign rech_mv    = (vreg_mv_i > ofs_mv) ? vreg_mv_i - ofs_mv : '0;
  assign rech_low_o = vbat_mv_i < rech_mv;
  assign cond       = term_en_i & ~reg_any_i & (ibat_ma_i < iterm_ma_i)
                    & (vbat_mv_i > rech_mv);

  // consecutive-sample filter; any miss or leaving charge clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (arm_i && cond) begin
      if (cnt_q != CNT_MAX)             cnt_q <= cnt_q + CW'(1);
    end else                            cnt_q <= '0;
  end

  assign term_ok_o = arm_i & cond & (cnt_q == CNT_MAX);
endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int MV_W         = 16,
  parameter int ICHG_W       = 6,
  parameter int TERM_SAMPLES = 8,
  parameter int SHORT_MV     = 2000,
  parameter int VLOW0_MV     = 2800,
  parameter int VLOW1_MV     = 3000,
  parameter int RECH0_MV     = 100,
  parameter int RECH1_MV     = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MV_W-1:0]   vbat_mv_i,
  input  logic [MV_W-1:0]   ibat_ma_i,
  input  logic [MV_W-1:0]   vreg_mv_i,
  input  logic [MV_W-1:0]   iterm_ma_i,
  input  logic [ICHG_W-1:0] ichg_code_i,
  input  logic              conv_on_i,
  input  logic              sw_en_i,
  input  logic              en_n_i,
  input  logic              tmr_fault_i,
  input  logic              bsw_dis_i,
  input  logic              reg_iin_i,
  input  logic              reg_vin_i,
  input  logic              reg_therm_i,
  input  logic              vlow_sel_i,
  input  logic              rech_sel_i,
  input  logic              term_en_i,
  output logic [1:0]        mode_o,
  output logic [1:0]        stat_o,
  output logic              done_o,
  output logic              bsw_en_o,
  output logic              done_evt_o
);
  chg_state_e state_q, state_d;
  logic       start_ok, below_low, rech_low, term_ok, evt_q;
  cur_mode_e  mode;

  chg_start_gate #(.ICHG_W(ICHG_W)) u_gate (
    .conv_on_i   (conv_on_i),
    .sw_en_i     (sw_en_i),
    .en_n_i      (en_n_i),
    .tmr_fault_i (tmr_fault_i),
    .bsw_dis_i   (bsw_dis_i),
    .ichg_code_i (ichg_code_i),
    .start_ok_o  (start_ok)
  );

  chg_mode_sel #(
    .MV_W(MV_W), .SHORT_MV(SHORT_MV), .VLOW0_MV(VLOW0_MV), .VLOW1_MV(VLOW1_MV)
  ) u_mode (
    .charging_i  (state_q == ST_CHG),
    .vbat_mv_i   (vbat_mv_i),
    .vlow_sel_i  (vlow_sel_i),
    .mode_o      (mode),
    .below_low_o (below_low)
  );

  chg_term_qual #(
    .MV_W(MV_W), .TERM_SAMPLES(TERM_SAMPLES), .RECH0_MV(RECH0_MV), .RECH1_MV(RECH1_MV)
  ) u_term (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state_q == ST_CHG),
    .vbat_mv_i  (vbat_mv_i),
    .ibat_ma_i  (ibat_ma_i),
    .vreg_mv_i  (vreg_mv_i),
    .iterm_ma_i (iterm_ma_i),
    .rech_sel_i (rech_sel_i),
    .term_en_i  (term_en_i),
    .reg_any_i  (reg_iin_i | reg_vin_i | reg_therm_i),
    .rech_low_o (rech_low),
    .term_ok_o  (term_ok)
  );

  always_comb begin
    state_d = state_q;
    if (!start_ok) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_CHG;
        ST_CHG:  if (term_ok)  state_d = ST_DONE;
        ST_DONE: if (rech_low) state_d = ST_CHG;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= (state_q == ST_CHG) && (state_d == ST_DONE);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CHG:  stat_o = below_low ? STAT_PRE : STAT_FAST;
      ST_DONE: stat_o = STAT_DONE;
      default: stat_o = STAT_OFF;
    endcase
  end

  assign mode_o     = mode;
  assign done_o     = (state_q == ST_DONE);
  assign bsw_en_o   = ~bsw_dis_i & (state_q != ST_DONE);
  assign done_evt_o = evt_q;
endmodule

// File: rtl/chg_cycle_ctrl_chk.sv
module chg_cycle_ctrl_chk #(
  parameter int ICHG_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ICHG_W-1:0] ichg_code_i,
  input logic              conv_on_i,
  input logic              term_en_i,
  input logic              reg_iin_i,
  input logic              reg_vin_i,
  input logic              reg_therm_i,
  input logic [1:0]        mode_o,
  input logic [1:0]        stat_o,
  input logic              done_o,
  input logic              bsw_en_o,
  input logic              done_evt_o
);
  p_gate_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_on_i |=> stat_o == 2'b00);

  p_zero_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ichg_code_i == '0) |=> stat_o == 2'b00);

  p_mode_in_charge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'b00) |-> (stat_o == 2'b01 || stat_o == 2'b10));

  p_term_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!term_en_i && stat_o != 2'b11) |=> stat_o != 2'b11);

  p_reg_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_iin_i || reg_vin_i || reg_therm_i) && stat_o != 2'b11) |=> stat_o != 2'b11);

  p_evt_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_o |=> !done_evt_o);

  p_evt_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_o |-> (done_o && !bsw_en_o && stat_o == 2'b11));

  p_evt_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> done_evt_o);
endmodule

bind chg_cycle_ctrl chg_cycle_ctrl_chk #(.ICHG_W(ICHG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ichg_code_i (ichg_code_i),
  .conv_on_i   (conv_on_i),
  .term_en_i   (term_en_i),
  .reg_iin_i   (reg_iin_i),
  .reg_vin_i   (reg_vin_i),
  .reg_therm_i (reg_therm_i),
  .mode_o      (mode_o),
  .stat_o      (stat_o),
  .done_o      (done_o),
  .bsw_en_o    (bsw_en_o),
  .done_evt_o  (done_evt_o)
);

// File: tb/chg_cycle_ctrl_bench.sv
module chg_cycle_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] vbat = 16'd1500, ibat = 16'd500, vreg = 16'd4200, iterm = 16'd256;
  logic [5:0]  ichg = 6'd0;
  logic conv_on = 0, sw_en = 1, en_n = 0, tmr_fault = 0, bsw_dis = 0;
  logic reg_iin = 0, reg_vin = 0, reg_therm = 0;
  logic vlow_sel = 0, rech_sel = 0, term_en = 1;
  logic [1:0] mode, stat;
  logic done, bsw_en, evt;

  typedef struct {
    logic [1:0] stat;
    logic [1:0] mode;
    logic       done;
    logic       bsw;
    logic       evt;
    string      tag;
  } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chg_cycle_ctrl u_chg_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vbat_mv_i(vbat), .ibat_ma_i(ibat),
    .vreg_mv_i(vreg), .iterm_ma_i(iterm), .ichg_code_i(ichg),
    .conv_on_i(conv_on), .sw_en_i(sw_en), .en_n_i(en_n),
    .tmr_fault_i(tmr_fault), .bsw_dis_i(bsw_dis), .reg_iin_i(reg_iin),
    .reg_vin_i(reg_vin), .reg_therm_i(reg_therm), .vlow_sel_i(vlow_sel),
    .rech_sel_i(rech_sel), .term_en_i(term_en), .mode_o(mode),
    .stat_o(stat), .done_o(done), .bsw_en_o(bsw_en), .done_evt_o(evt)
  );

  // monitor
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (stat !== e.stat || mode !== e.mode || done !== e.done ||
          bsw_en !== e.bsw || evt !== e.evt) begin
        n_bad++;
        $display("FAIL %s: stat/mode/done/bsw/evt act %b/%b/%b/%b/%b exp %b/%b/%b/%b/%b",
                 e.tag, stat, mode, done, bsw_en, evt,
                 e.stat, e.mode, e.done, e.bsw, e.evt);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [1:0] s, input logic [1:0] m,
                            input logic d, input logic b, input logic ev,
                            input string tag);
    exp_t e;
    e.stat = s; e.mode = m; e.done = d; e.bsw = b; e.evt = ev; e.tag = tag;
    q.push_back(e);
    #2;
  endtask

  // drive to done: conditions already qualifying and state in charge
  task automatic run_to_done(input string tag);
    step(7);
    expect_out(2'b10, 2'b11, 0, 1, 0, tag);
    step(1);
    expect_out(2'b11, 2'b00, 1, 0, 1, tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: act timeout exp completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R11 reset");
    rst_n = 1; conv_on = 1;
    step(2);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R12 zero code blocks start");

    ichg = 6'd10;
    step(1);
    expect_out(2'b01, 2'b01, 0, 1, 0, "R2 short-battery mode");
    vbat = 16'd2500; step(1);
    expect_out(2'b01, 2'b10, 0, 1, 0, "R4 precharge status");
    vbat = 16'd2900; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R3 low threshold 2800");
    vlow_sel = 1; step(1);
    expect_out(2'b01, 2'b10, 0, 1, 0, "R3 low threshold 3000");
    vbat = 16'd3000; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R2 fast at threshold");

    // regulation and term-enable suppress termination
    vbat = 16'd4150; ibat = 16'd100; reg_therm = 1;
    step(12);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R7 thermal regulation");
    reg_therm = 0; reg_iin = 1; step(12);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R7 input current regulation");
    reg_iin = 0; term_en = 0; step(12);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R6 termination disabled");

    // eighth sample broken by current spike, then by voltage regulation
    term_en = 1;
    step(7);
    ibat = 16'd300; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R5 broken on eighth sample");
    ibat = 16'd100; step(7);
    reg_vin = 1; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R7 regulation on eighth sample");
    reg_vin = 0;
    run_to_done("R5 R8 termination");
    step(1);
    expect_out(2'b11, 2'b00, 1, 0, 0, "R8 single-cycle event");

    // recharge offset 100 mV
    vbat = 16'd4100; step(3);
    expect_out(2'b11, 2'b00, 1, 0, 0, "R9 at threshold stays done");
    vbat = 16'd4099; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R9 recharge below 100 mV offset");
    // offset 200 mV
    rech_sel = 1; vbat = 16'd4090;
    run_to_done("R9 done again");
    vbat = 16'd4050; step(2);
    expect_out(2'b11, 2'b00, 1, 0, 0, "R9 above 200 mV offset");
    vbat = 16'd3990; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R9 recharge below 200 mV offset");

    // restart by toggling the pin, then the software bit
    vbat = 16'd4090;
    run_to_done("R10 done before pin toggle");
    en_n = 1; step(1);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R10 pin high");
    en_n = 0; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R10 pin restart");
    run_to_done("R10 done before bit toggle");
    sw_en = 0; step(1);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R10 bit cleared");
    sw_en = 1; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R10 bit restart");

    // remaining gates
    ibat = 16'd500;
    tmr_fault = 1; step(1);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R1 timer fault");
    tmr_fault = 0; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R1 fault cleared");
    bsw_dis = 1; step(1);
    expect_out(2'b00, 2'b00, 0, 0, 0, "R1 switch disable");
    bsw_dis = 0; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R1 switch re-enabled");
    conv_on = 0; step(1);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R1 converter off");
    conv_on = 1; step(1);
    expect_out(2'b10, 2'b11, 0, 1, 0, "R1 converter back");
    ichg = 6'd0; step(1);
    expect_out(2'b00, 2'b00, 0, 1, 0, "R12 zero code stops cycle");

    step(2);
    finished = 1;
    finish_run();
  end
endmodule